// File: doc/BRIEF.md
# Flash Configuration Reload Sequencer

This block brings up a programmable-logic device by copying its configuration image from parallel NOR flash into a byte-wide configuration port. The flash is split into equal sectors, and each sector may hold one image. After reset the sequencer always starts at a fixed boot sector. It streams bytes from the start of that sector and watches the configuration logic's completion and error inputs. When an attempt fails, the sequencer pulses a configuration-restart output and moves on to the next sector. It keeps doing this until one image loads or the last sector has been tried.

Software can request a reload from any sector through a small four-register interface. It first writes the wanted sector index, then writes a three-step unlock sequence to the control register, and the final step of that sequence starts the reload. A 32-bit user word in the register bank is never touched by a reload, so state can be carried across a reconfiguration. The status word shows which sector the running image came from, whether the sequencer is busy, and whether every remaining sector has failed.

The sector size and the sector count must be powers of two. The count must be at most 256, and the timeout width at most 32 bits.

Top module: `cfg_reload_seq`

## Requirements
- R1: After reset the first attempt begins at sector BOOT_SECTOR (default 2), and its first flash read uses byte address BOOT_SECTOR*SECTOR_SIZE.
- R2: During an attempt, reads go to consecutive byte addresses starting at the sector base, one per cycle. Each byte returned by the flash (one cycle after its read) is presented on `cfg_data` with `cfg_wr` high in that cycle.
- R3: An attempt fails when the number of reads issued in it reaches the timeout register (address 3, reset value DEF_TIMEOUT) without `cfg_done`. A timed-out attempt therefore delivers exactly that many bytes.
- R4: `cfg_err` high during an attempt ends it as failed, and the sequencer moves on to the next sector.
- R5: Each attempt is preceded by one cycle of `cfg_prog`, and a failed attempt advances to the next sector index. After a failure in the last sector the sequencer sets a sticky fail flag (status bit 31), clears busy, and issues no more reads.
- R6: `cfg_done` high during an attempt ends it as successful. This sets status bit 29, writes the sector index to status bits [7:0], clears busy, and stops all reads and restart pulses.
- R7: Three writes to register 0 whose low bytes are 0xA5, 0x5A and 0xC3, in that order, start a new attempt at the sector index held in register 1 (low bits). The third write clears the fail and success flags.
- R8: Any register write other than the next expected unlock value resets the unlock progress to the beginning, so the wrong order or an interleaved write starts nothing.
- R9: Register 2 holds a 32-bit user word that only reset clears and that reads back unchanged after any reload.
- R10: Status bit 30 is high while an attempt is in progress, and status bits [15:8] give the sector currently being tried. A reload shows busy and its start sector in the cycle after the last unlock write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control/status, 1 sector select, 2 user word, 3 timeout |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| flash_rd_en | output | 1 | Flash read request |
| flash_addr | output | log2(NUM_SECTORS*SECTOR_SIZE) | Flash byte address |
| flash_rdata | input | 8 | Flash data, valid one cycle after the request |
| cfg_prog | output | 1 | One-cycle restart pulse before each attempt |
| cfg_wr | output | 1 | Configuration byte strobe |
| cfg_data | output | 8 | Configuration byte |
| cfg_done | input | 1 | Configuration logic reports a successful load |
| cfg_err | input | 1 | Configuration logic reports a load error |

## Verification
The main sweep resets the sequencer once for each possible position of the first good sector, from the boot sector up to "none at all". The failing sectors in front of the good one alternate between timeouts and error reports. This separates correct sector advance, exact timeout byte counts and the error path from the final fail-flag case. Every streamed byte is compared with an arithmetic flash pattern tied to the predicted sector, which exposes wrong start addresses or skipped bytes. A second sweep reloads from every sector index, with an error in the chosen sector so that the advance after a software start is also seen. Broken unlock orders, a shortened timeout and recovery from the fail flag are tried separately.

// File: rtl/cfg_reload_pkg.sv
package cfg_reload_pkg;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_LOAD  = 2'd1,
        ST_IDLE  = 2'd2
    } ld_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_SECT = 2'd1;
    localparam logic [1:0] REG_USER = 2'd2;
    localparam logic [1:0] REG_TMO  = 2'd3;

    localparam logic [7:0] KEY_0 = 8'hA5;
    localparam logic [7:0] KEY_1 = 8'h5A;
    localparam logic [7:0] KEY_2 = 8'hC3;

    localparam int STAT_FAIL_BIT = 31;
    localparam int STAT_BUSY_BIT = 30;
    localparam int STAT_OK_BIT   = 29;
    localparam int STAT_CUR_LSB  = 8;
    localparam int STAT_LD_LSB   = 0;

endpackage

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq
    import cfg_reload_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic [7:0] cmd,
    output logic       go
);

    typedef struct packed {
        logic [1:0] step;
    } unl_t;

    unl_t q, d;
    logic key_hit;

    always_comb begin
        d  = q;
        go = 1'b0;
        unique case (q.step)
            2'd0:    key_hit = (cmd == KEY_0);
            2'd1:    key_hit = (cmd == KEY_1);
            default: key_hit = (cmd == KEY_2);
        endcase
        if (wr) begin
            if (addr == REG_CTRL && key_hit) begin
                if (q.step == 2'd2) begin
                    go     = 1'b1;
                    d.step = 2'd0;
                end else begin
                    d.step = q.step + 2'd1;
                end
            end else begin
                d.step = 2'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_reload_pkg::*;
#(
    parameter int SEC_W       = 4,
    parameter int TO_W        = 20,
    parameter int BOOT_SECTOR = 2,
    parameter int DEF_TIMEOUT = 65536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [31:0]      wdata,
    input  logic [31:0]      status,
    output logic [SEC_W-1:0] sel_sector,
    output logic [TO_W-1:0]  timeout,
    output logic [31:0]      rdata
);

    typedef struct packed {
        logic [SEC_W-1:0] sel;
        logic [31:0]      user;
        logic [TO_W-1:0]  tmo;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr) begin
            unique case (addr)
                REG_SECT: d.sel  = wdata[SEC_W-1:0];
                REG_USER: d.user = wdata;
                REG_TMO:  d.tmo  = wdata[TO_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_CTRL: rdata = status;
            REG_SECT: rdata[SEC_W-1:0] = q.sel;
            REG_USER: rdata = q.user;
            default:  rdata[TO_W-1:0] = q.tmo;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sel  <= SEC_W'(BOOT_SECTOR);
            q.user <= '0;
            q.tmo  <= TO_W'(DEF_TIMEOUT);
        end else begin
            q <= d;
        end
    end

    assign sel_sector = q.sel;
    assign timeout    = q.tmo;

endmodule

// File: rtl/cfg_load_engine.sv
module cfg_load_engine
    import cfg_reload_pkg::*;
#(
    parameter int NUM_SECTORS = 16,
    parameter int SB          = 16,
    parameter int TO_W        = 20,
    parameter int BOOT_SECTOR = 2,
    localparam int SEC_W      = $clog2(NUM_SECTORS),
    localparam int AW         = SEC_W + SB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [SEC_W-1:0] go_sector,
    input  logic [TO_W-1:0]  timeout,
    input  logic             cfg_done,
    input  logic             cfg_err,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    output logic             prog,
    output logic             wr_strobe,
    output logic             busy,
    output logic             ok,
    output logic             fail,
    output logic [SEC_W-1:0] cur_sector,
    output logic [SEC_W-1:0] loaded_sector
);

    localparam logic [SEC_W-1:0] LAST = SEC_W'(NUM_SECTORS - 1);

    typedef struct packed {
        ld_state_e        state;
        logic [SEC_W-1:0] cur;
        logic [TO_W-1:0]  cnt;
        logic             rd_pend;
        logic             ok;
        logic             fail;
        logic [SEC_W-1:0] loaded;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d         = q;
        d.rd_pend = 1'b0;
        unique case (q.state)
            ST_START: begin
                d.state = ST_LOAD;
                d.cnt   = '0;
            end
            ST_LOAD: begin
                if (cfg_done) begin
                    d.ok     = 1'b1;
                    d.loaded = q.cur;
                    d.state  = ST_IDLE;
                end else if (cfg_err || q.cnt == timeout) begin
                    if (q.cur == LAST) begin
                        d.fail  = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        d.cur   = q.cur + SEC_W'(1);
                        d.state = ST_START;
                    end
                end else begin
                    d.rd_pend = 1'b1;
                    d.cnt     = q.cnt + TO_W'(1);
                end
            end
            default: ;
        endcase
        if (go) begin
            d.state   = ST_START;
            d.cur     = go_sector;
            d.ok      = 1'b0;
            d.fail    = 1'b0;
            d.rd_pend = 1'b0;
        end
        rd_en = d.rd_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_START;
            q.cur     <= SEC_W'(BOOT_SECTOR);
            q.cnt     <= '0;
            q.rd_pend <= 1'b0;
            q.ok      <= 1'b0;
            q.fail    <= 1'b0;
            q.loaded  <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_addr       = (AW'(q.cur) << SB) + AW'(q.cnt);
    assign prog          = (q.state == ST_START);
    assign wr_strobe     = q.rd_pend;
    assign busy          = (q.state != ST_IDLE);
    assign ok            = q.ok;
    assign fail          = q.fail;
    assign cur_sector    = q.cur;
    assign loaded_sector = q.loaded;

endmodule

// File: rtl/cfg_reload_seq.sv
module cfg_reload_seq
    import cfg_reload_pkg::*;
#(
    parameter int NUM_SECTORS = 16,
    parameter int SECTOR_SIZE = 65536,
    parameter int BOOT_SECTOR = 2,
    parameter int TO_W        = 20,
    parameter int DEF_TIMEOUT = 65536,
    localparam int SEC_W      = $clog2(NUM_SECTORS),
    localparam int SB         = $clog2(SECTOR_SIZE),
    localparam int FLASH_AW   = SEC_W + SB
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                flash_rd_en,
    output logic [FLASH_AW-1:0] flash_addr,
    input  logic [7:0]          flash_rdata,
    output logic                cfg_prog,
    output logic                cfg_wr,
    output logic [7:0]          cfg_data,
    input  logic                cfg_done,
    input  logic                cfg_err
);

    logic             unlock_go;
    logic [SEC_W-1:0] sel_sector;
    logic [TO_W-1:0]  timeout;
    logic             eng_busy;
    logic             eng_ok;
    logic             eng_fail;
    logic [SEC_W-1:0] cur_sector;
    logic [SEC_W-1:0] loaded_sector;
    logic [31:0]      status;

    cfg_unlock_seq u_unlock (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .cmd   (reg_wdata[7:0]),
        .go    (unlock_go)
    );

    cfg_reg_bank #(
        .SEC_W       (SEC_W),
        .TO_W        (TO_W),
        .BOOT_SECTOR (BOOT_SECTOR),
        .DEF_TIMEOUT (DEF_TIMEOUT)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .status     (status),
        .sel_sector (sel_sector),
        .timeout    (timeout),
        .rdata      (reg_rdata)
    );

    cfg_load_engine #(
        .NUM_SECTORS (NUM_SECTORS),
        .SB          (SB),
        .TO_W        (TO_W),
        .BOOT_SECTOR (BOOT_SECTOR)
    ) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (unlock_go),
        .go_sector     (sel_sector),
        .timeout       (timeout),
        .cfg_done      (cfg_done),
        .cfg_err       (cfg_err),
        .rd_en         (flash_rd_en),
        .rd_addr       (flash_addr),
        .prog          (cfg_prog),
        .wr_strobe     (cfg_wr),
        .busy          (eng_busy),
        .ok            (eng_ok),
        .fail          (eng_fail),
        .cur_sector    (cur_sector),
        .loaded_sector (loaded_sector)
    );

    always_comb begin
        status                            = '0;
        status[STAT_FAIL_BIT]             = eng_fail;
        status[STAT_BUSY_BIT]             = eng_busy;
        status[STAT_OK_BIT]               = eng_ok;
        status[STAT_CUR_LSB +: SEC_W]     = cur_sector;
        status[STAT_LD_LSB +: SEC_W]      = loaded_sector;
    end

    assign cfg_data = flash_rdata;

endmodule

// File: rtl/cfg_reload_seq_chk.sv
module cfg_reload_seq_chk #(
    parameter int AW = 20,
    parameter int SB = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flash_rd_en,
    input logic [AW-1:0] flash_addr,
    input logic          cfg_wr,
    input logic          cfg_prog,
    input logic          eng_busy,
    input logic          eng_ok,
    input logic          eng_fail,
    input logic          unlock_go
);

    assert_wr_after_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |-> $past(flash_rd_en));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_rd_en && $past(flash_rd_en)) |-> ((flash_addr - $past(flash_addr)) == AW'(1)));

    assert_attempt_at_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_prog |=> (!flash_rd_en || flash_addr[SB-1:0] == '0));

    assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_fail && !unlock_go) |=> eng_fail);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (!flash_rd_en && !cfg_prog));

    assert_ok_fail_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_ok && eng_fail));

    assert_go_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unlock_go |=> (cfg_prog && eng_busy && !eng_fail));

endmodule

bind cfg_reload_seq cfg_reload_seq_chk #(.AW(FLASH_AW), .SB(SB)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flash_rd_en (flash_rd_en),
    .flash_addr  (flash_addr),
    .cfg_wr      (cfg_wr),
    .cfg_prog    (cfg_prog),
    .eng_busy    (eng_busy),
    .eng_ok      (eng_ok),
    .eng_fail    (eng_fail),
    .unlock_go   (unlock_go)
);

// File: tb/cfg_reload_seq_tb_top.sv
`timescale 1ns/1ps
module cfg_reload_seq_tb_top;

    localparam int NS   = 8;
    localparam int SS   = 32;
    localparam int BOOT = 2;
    localparam int DEFT = 12;
    localparam int AW   = 8;

    localparam int M_TMO  = 0;
    localparam int M_ERR  = 1;
    localparam int M_GOOD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        flash_rd_en;
    logic [AW-1:0] flash_addr;
    logic [7:0]  flash_rdata = '0;
    logic        cfg_prog;
    logic        cfg_wr;
    logic [7:0]  cfg_data;
    logic        cfg_done = 1'b0;
    logic        cfg_err = 1'b0;

    always #5 clk = ~clk;

    cfg_reload_seq #(
        .NUM_SECTORS (NS),
        .SECTOR_SIZE (SS),
        .BOOT_SECTOR (BOOT),
        .TO_W        (8),
        .DEF_TIMEOUT (DEFT)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .flash_rd_en (flash_rd_en),
        .flash_addr  (flash_addr),
        .flash_rdata (flash_rdata),
        .cfg_prog    (cfg_prog),
        .cfg_wr      (cfg_wr),
        .cfg_data    (cfg_data),
        .cfg_done    (cfg_done),
        .cfg_err     (cfg_err)
    );

    int checks = 0;
    int errors = 0;

    int mode  [NS];
    int kb    [NS];
    int wcount[NS];
    int prog_cnt = 0;
    int rd_cnt = 0;
    int mism = 0;
    int trk = 0;
    int bcnt = 0;
    int next_start = BOOT;
    bit fresh = 1'b1;
    bit first_rd = 1'b1;
    int first_addr = -1;

    function automatic logic [7:0] fpat(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    // flash and configuration-logic models
    always @(posedge clk) begin
        if (flash_rd_en) begin
            flash_rdata <= fpat(int'(flash_addr));
            rd_cnt = rd_cnt + 1;
            if (first_rd) begin
                first_addr = int'(flash_addr);
                first_rd   = 1'b0;
            end
        end
        if (!rst_n) begin
            cfg_done <= 1'b0;
            cfg_err  <= 1'b0;
            bcnt = 0;
        end else if (cfg_prog) begin
            cfg_done <= 1'b0;
            cfg_err  <= 1'b0;
            bcnt = 0;
            prog_cnt = prog_cnt + 1;
            if (fresh) begin
                trk   = next_start;
                fresh = 1'b0;
            end else begin
                trk = trk + 1;
            end
        end else if (cfg_wr) begin
            if (cfg_data !== fpat(trk * SS + bcnt)) mism = mism + 1;
            wcount[trk] = wcount[trk] + 1;
            bcnt = bcnt + 1;
            if (bcnt == kb[trk]) begin
                if (mode[trk] == M_GOOD) cfg_done <= 1'b1;
                if (mode[trk] == M_ERR)  cfg_err  <= 1'b1;
            end
        end
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic clear_stats();
        for (int i = 0; i < NS; i++) wcount[i] = 0;
        prog_cnt = 0;
        rd_cnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fresh = 1'b1; next_start = BOOT; first_rd = 1'b1;
        clear_stats();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reg_read(2'd0, s);
            if (!s[30]) break;
        end
    endtask

    task automatic unlock();
        reg_write(2'd0, 32'hA5);
        reg_write(2'd0, 32'h5A);
        reg_write(2'd0, 32'hC3);
    endtask

    task automatic set_modes(input int first_good, input int kgood);
        for (int s = 0; s < NS; s++) begin
            if (s >= first_good) begin mode[s] = M_GOOD; kb[s] = kgood; end
            else if (s % 2 == 0) begin mode[s] = M_TMO; kb[s] = 0; end
            else begin mode[s] = M_ERR; kb[s] = 3; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] s;
        int          r0;
        int          p0;

        // reset state
        set_modes(NS, 4);
        @(negedge clk);
        reg_read(2'd0, s);
        chk(s[31] == 0 && s[29] == 0, "R10", "flags in reset", int'(s[31:29]), 0);
        reg_read(2'd3, s);
        chk(s == DEFT, "R3", "timeout reset value", int'(s), DEFT);

        // sweep over the first good sector after power-up
        for (int g = BOOT; g <= NS; g++) begin
            set_modes(g, 4 + (g % 4));
            do_reset();
            wait_idle();
            reg_read(2'd0, s);
            chk(first_addr == BOOT * SS, "R1", "first read address", first_addr, BOOT * SS);
            if (g < NS) begin
                chk(s[29] == 1 && s[31] == 0, "R6", "success flags", int'(s[31:29]), 1);
                chk(int'(s[7:0]) == g, "R6", "loaded sector", int'(s[7:0]), g);
                chk(prog_cnt == g - BOOT + 1, "R5", "attempts", prog_cnt, g - BOOT + 1);
                chk(wcount[g] == kb[g] + 1, "R6", "bytes in good sector", wcount[g], kb[g] + 1);
            end else begin
                chk(s[31] == 1 && s[29] == 0, "R5", "fail flag after last", int'(s[31:29]), 4);
                chk(prog_cnt == NS - BOOT, "R5", "attempts", prog_cnt, NS - BOOT);
            end
            chk(s[30] == 0, "R10", "busy clear at end", int'(s[30]), 0);
            for (int t = BOOT; t < g && t < NS; t++) begin
                if (mode[t] == M_TMO)
                    chk(wcount[t] == DEFT, "R3", "timeout byte count", wcount[t], DEFT);
                else
                    chk(wcount[t] == 4, "R4", "error stop byte count", wcount[t], 4);
            end
            chk(mism == 0, "R2", "streamed data mismatches", mism, 0);
            r0 = rd_cnt; p0 = prog_cnt;
            repeat (20) @(negedge clk);
            chk(rd_cnt == r0 && prog_cnt == p0, "R6", "quiet after end", rd_cnt - r0, 0);
        end

        // reload from every sector; user word survives
        set_modes(0, 5);
        do_reset();
        wait_idle();
        reg_write(2'd2, 32'hDEADBEEF);
        for (int sel = 0; sel < NS; sel++) begin
            set_modes(0, 5);
            if (sel < NS - 1) begin mode[sel] = M_ERR; kb[sel] = 3; end
            clear_stats();
            reg_write(2'd1, 32'(sel));
            fresh = 1'b1; next_start = sel;
            unlock();
            reg_read(2'd0, s);
            chk(s[30] == 1 && int'(s[15:8]) == sel, "R10", "busy and start sector after unlock",
                int'(s[15:8]), sel);
            wait_idle();
            reg_read(2'd0, s);
            chk(int'(s[7:0]) == (sel < NS - 1 ? sel + 1 : sel) && s[29] == 1, "R7",
                "reload loaded sector", int'(s[7:0]), (sel < NS - 1 ? sel + 1 : sel));
            reg_read(2'd2, s);
            chk(s == 32'hDEADBEEF, "R9", "user word after reload", int'(s), int'(32'hDEADBEEF));
            chk(mism == 0, "R2", "reload data mismatches", mism, 0);
        end

        // broken unlock orders start nothing
        p0 = prog_cnt;
        reg_write(2'd0, 32'hA5); reg_write(2'd0, 32'h5A); reg_write(2'd0, 32'h00); reg_write(2'd0, 32'hC3);
        reg_write(2'd0, 32'hA5); reg_write(2'd1, 32'd3);  reg_write(2'd0, 32'h5A); reg_write(2'd0, 32'hC3);
        reg_write(2'd0, 32'h5A); reg_write(2'd0, 32'hC3);
        reg_write(2'd0, 32'hA5); reg_write(2'd0, 32'hA5); reg_write(2'd0, 32'h5A); reg_write(2'd0, 32'hC3);
        repeat (5) @(negedge clk);
        reg_read(2'd0, s);
        chk(prog_cnt == p0 && s[30] == 0, "R8", "no reload from broken sequences", prog_cnt - p0, 0);

        // shortened timeout, reload from sector 3 (timeout) to 4 (good)
        reg_write(2'd3, 32'd5);
        reg_read(2'd3, s);
        chk(s == 5, "R3", "timeout register readback", int'(s), 5);
        set_modes(4, 3);
        mode[3] = M_TMO; kb[3] = 0;
        clear_stats();
        fresh = 1'b1; next_start = 3;
        unlock();
        wait_idle();
        reg_read(2'd0, s);
        chk(wcount[3] == 5, "R3", "bytes before short timeout", wcount[3], 5);
        chk(int'(s[7:0]) == 4, "R8", "correct sequence after broken ones", int'(s[7:0]), 4);

        // fail flag, then cleared by an unlocked reload
        set_modes(NS, 3);
        do_reset();
        wait_idle();
        reg_read(2'd0, s);
        chk(s[31] == 1, "R5", "fail flag set", int'(s[31]), 1);
        repeat (10) @(negedge clk);
        reg_read(2'd0, s);
        chk(s[31] == 1, "R5", "fail flag sticky", int'(s[31]), 1);
        mode[5] = M_GOOD; kb[5] = 3;
        reg_write(2'd1, 32'd5);
        fresh = 1'b1; next_start = 5;
        unlock();
        wait_idle();
        reg_read(2'd0, s);
        chk(s[31] == 0 && s[29] == 1 && s[7:0] == 5, "R7", "fail cleared by reload",
            int'(s[31:29]), 1);
        chk(mism == 0, "R2", "final data mismatches", mism, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule